// File: doc/BRIEF.md
# Packed Floating-Point Magnitude Less-or-Equal Compare

This unit compares two packed floating-point vectors lane by lane on magnitude alone. For every lane it discards the sign of both elements and writes a lane-wide mask that is all ones when the first element's magnitude does not exceed the second's, and all zeros otherwise. The lanes hold either half-precision (16-bit) or single-precision (32-bit) values. A request covers either the low 64 bits or the full 128 bits of the operands.

The controls come from a 32-bit instruction word that the unit decodes itself. The decoder checks the fixed opcode pattern and reads the element-size bit, the vector-length bit and three 5-bit register numbers. The caller supplies the two operand values, already read from its register file. The first operand is the register named by the first-source field and the second is the register named by the second-source field. The result appears one clock after the request. It comes with a valid flag and the destination register number. A wide-mode request that names an odd register raises an undefined-instruction flag instead of a result.

Top module: `fpmc_absle_unit`

## Requirements
- R1: In each active lane, out_mask is all ones when |first| <= |second| (equal magnitudes included) and all zeros otherwise; every lane is uniformly all ones or all zeros.
- R2: Instruction bit 20 selects the lane type. A value of 0 gives four 32-bit single-precision lanes (exponent 8 bits). A value of 1 gives eight 16-bit half-precision lanes (exponent 5 bits).
- R3: Instruction bit 6 selects the vector length. A value of 0 processes only bits [63:0] and drives out_mask[127:64] to zero whatever the operands hold. A value of 1 processes all 128 bits.
- R4: The sign bit plays no part in the result. +0 against -0 gives all ones. Subnormals and infinities order by their unsigned magnitude bits.
- R5: If either element of a lane is a NaN (exponent all ones, fraction non-zero), that lane's mask is all zeros.
- R6: An instruction word is recognised only when all of these hold: bits [31:25]=1111001, bit 24=1, bit 23=0, bit 21=0, bits [11:8]=1110 and bit 4=1. Any other word raises neither out_valid nor out_undef.
- R7: In 128-bit mode, if any of the register numbers {bit22,bits[15:12]}, {bit7,bits[19:16]} or {bit5,bits[3:0]} is odd, out_undef pulses one clock later and out_valid stays low. In 64-bit mode odd numbers are accepted.
- R8: An accepted request raises out_valid for exactly one clock, at the clock edge that follows it, together with its mask. At the same edge out_rd carries the destination register number {bit22,bits[15:12]}. Back-to-back requests give back-to-back results.
- R9: A synchronous active-high reset clears out_valid and out_undef, and drops a request that is presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_insn | input | 32 | Instruction word |
| in_opa | input | 128 | First operand vector (first-source register) |
| in_opb | input | 128 | Second operand vector (second-source register) |
| out_valid | output | 1 | Result valid, one clock after an accepted request |
| out_undef | output | 1 | Undefined-instruction pulse (odd register in 128-bit mode) |
| out_rd | output | 5 | Destination register number of the result |
| out_mask | output | 128 | Per-lane compare mask |

## Verification
A fault in one lane comparator, or in the NaN detector, shows in that lane's slice of out_mask on the result of the same request. A wrong size or length selection shows as a split lane or as non-zero upper bits at that same edge. A decode error surfaces one clock later, either as a missing or extra out_valid pulse or as a wrong out_undef pulse. The directed scenarios therefore compare every result cycle, and the cycle after it, against a lane model derived from the requirements.

// File: rtl/fpmc_pkg.sv
package fpmc_pkg;

    localparam int VEC_W      = 128;
    localparam int HALF_W     = 16;
    localparam int HALF_EXP   = 5;
    localparam int SINGLE_W   = 32;
    localparam int SINGLE_EXP = 8;
    localparam int INSN_W     = 32;
    localparam int REG_W      = 5;

    typedef enum logic {
        ESZ_SINGLE = 1'b0,
        ESZ_HALF   = 1'b1
    } esize_e;

    typedef enum logic {
        VLEN_64  = 1'b0,
        VLEN_128 = 1'b1
    } vlen_e;

    typedef struct packed {
        logic             hit;
        logic             undef;
        esize_e           esz;
        vlen_e            vlen;
        logic [REG_W-1:0] rd;
    } dec_t;

    // Every lane of the given size is all ones or all zeros.
    function automatic logic lanes_uniform(logic [VEC_W-1:0] m, esize_e esz);
        logic ok;
        ok = 1'b1;
        if (esz == ESZ_HALF) begin
            for (int i = 0; i < VEC_W / HALF_W; i++) begin
                if (m[i*HALF_W +: HALF_W] != '0 && m[i*HALF_W +: HALF_W] != '1)
                    ok = 1'b0;
            end
        end else begin
            for (int i = 0; i < VEC_W / SINGLE_W; i++) begin
                if (m[i*SINGLE_W +: SINGLE_W] != '0 && m[i*SINGLE_W +: SINGLE_W] != '1)
                    ok = 1'b0;
            end
        end
        return ok;
    endfunction

endpackage

// File: rtl/fpmc_decode.sv
module fpmc_decode
    import fpmc_pkg::*;
#(
    parameter int IW = INSN_W
) (
    input  logic [IW-1:0] insn,
    output dec_t          dec
);

    logic [REG_W-1:0] rd, rn, rm;
    logic             wide;

    always_comb begin
        rd   = {insn[22], insn[15:12]};
        rn   = {insn[7],  insn[19:16]};
        rm   = {insn[5],  insn[3:0]};
        wide = insn[6];

        dec.hit   = (insn[31:25] == 7'b1111001) && insn[24] && !insn[23]
                  && !insn[21] && (insn[11:8] == 4'b1110) && insn[4];
        dec.esz   = esize_e'(insn[20]);
        dec.vlen  = vlen_e'(wide);
        dec.rd    = rd;
        dec.undef = dec.hit && wide && (rd[0] || rn[0] || rm[0]);
    end

endmodule

// File: rtl/fpmc_lane.sv
module fpmc_lane #(
    parameter int EW    = 32,
    parameter int EXP_W = 8
) (
    input  logic [EW-1:0] first,
    input  logic [EW-1:0] second,
    output logic          le
);

    localparam int MAG_W = EW - 1;
    localparam int MAN_W = MAG_W - EXP_W;
    localparam logic [EW-1:0] SIGN_CLR = {1'b0, {MAG_W{1'b1}}};

    logic [EW-1:0] mag_f, mag_s;
    logic          nan_f, nan_s;

    always_comb begin
        mag_f = first  & SIGN_CLR;
        mag_s = second & SIGN_CLR;
        nan_f = (&mag_f[MAG_W-1 -: EXP_W]) && (|mag_f[MAN_W-1:0]);
        nan_s = (&mag_s[MAG_W-1 -: EXP_W]) && (|mag_s[MAN_W-1:0]);
        // less-or-equal realised as greater-or-equal with operands swapped
        le    = !nan_f && !nan_s && (mag_s >= mag_f);
    end

endmodule

// File: rtl/fpmc_mask.sv
module fpmc_mask
    import fpmc_pkg::*;
#(
    parameter int VW   = VEC_W,
    parameter int HW   = HALF_W,
    parameter int HEXP = HALF_EXP,
    parameter int SW   = SINGLE_W,
    parameter int SEXP = SINGLE_EXP
) (
    input  logic [VW-1:0] opa,
    input  logic [VW-1:0] opb,
    input  esize_e        esz,
    input  vlen_e         vlen,
    output logic [VW-1:0] mask
);

    localparam int NH = VW / HW;
    localparam int NS = VW / SW;

    logic [NH-1:0] le_h;
    logic [NS-1:0] le_s;
    logic [VW-1:0] mask_h, mask_s;

    for (genvar h = 0; h < NH; h++) begin : g_half
        fpmc_lane #(.EW(HW), .EXP_W(HEXP)) u_lane (
            .first (opa[h*HW +: HW]),
            .second(opb[h*HW +: HW]),
            .le    (le_h[h])
        );
    end

    for (genvar s = 0; s < NS; s++) begin : g_single
        fpmc_lane #(.EW(SW), .EXP_W(SEXP)) u_lane (
            .first (opa[s*SW +: SW]),
            .second(opb[s*SW +: SW]),
            .le    (le_s[s])
        );
    end

    always_comb begin
        for (int i = 0; i < NH; i++) mask_h[i*HW +: HW] = {HW{le_h[i]}};
        for (int i = 0; i < NS; i++) mask_s[i*SW +: SW] = {SW{le_s[i]}};
        mask = (esz == ESZ_HALF) ? mask_h : mask_s;
        if (vlen == VLEN_64) mask[VW-1:VW/2] = '0;
    end

endmodule

// File: rtl/fpmc_absle_unit.sv
module fpmc_absle_unit
    import fpmc_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int IW = INSN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IW-1:0]    in_insn,
    input  logic [VW-1:0]    in_opa,
    input  logic [VW-1:0]    in_opb,
    output logic             out_valid,
    output logic             out_undef,
    output logic [REG_W-1:0] out_rd,
    output logic [VW-1:0]    out_mask
);

    dec_t          dec;
    logic [VW-1:0] mask_c;
    logic          accept;

    fpmc_decode #(.IW(IW)) u_dec (
        .insn(in_insn),
        .dec (dec)
    );

    fpmc_mask #(.VW(VW)) u_mask (
        .opa (in_opa),
        .opb (in_opb),
        .esz (dec.esz),
        .vlen(dec.vlen),
        .mask(mask_c)
    );

    assign accept = in_valid && dec.hit && !dec.undef;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_undef <= 1'b0;
        end else begin
            out_valid <= accept;
            out_undef <= in_valid && dec.undef;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            out_mask <= mask_c;
            out_rd   <= dec.rd;
        end
    end

    // R8
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R7
    undef_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_undef));

    // R7
    undef_wide_only_chk: assert property (@(posedge clk) disable iff (rst)
        out_undef |-> ($past(in_valid) && $past(in_insn[6])));

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(in_insn[6])) |-> (out_mask[VW-1:VW/2] == '0));

    // R1
    lane_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> lanes_uniform(out_mask, esize_e'($past(in_insn[20]))));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !in_valid) |=> !out_valid);

endmodule

// File: tb/test_fpmc_absle_unit.sv
module test_fpmc_absle_unit;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  in_insn = '0;
    logic [127:0] in_opa = '0;
    logic [127:0] in_opb = '0;
    logic         out_valid, out_undef;
    logic [4:0]   out_rd;
    logic [127:0] out_mask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fpmc_absle_unit i_fpmc_absle_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
        .in_opa(in_opa), .in_opb(in_opb), .out_valid(out_valid),
        .out_undef(out_undef), .out_rd(out_rd), .out_mask(out_mask)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit half, bit wide, logic [4:0] d, logic [4:0] n, logic [4:0] m);
        return 32'hF300_0E10 | (32'(half) << 20) | (32'(wide) << 6)
             | (32'(d[4]) << 22) | (32'(d[3:0]) << 12)
             | (32'(n[4]) << 7)  | (32'(n[3:0]) << 16)
             | (32'(m[4]) << 5)  | 32'(m[3:0]);
    endfunction

    function automatic logic [127:0] ref_mask(bit half, bit wide, logic [127:0] a, logic [127:0] b);
        logic [127:0] r;
        int w, ew;
        r = '0;
        w = half ? 16 : 32;
        ew = half ? 5 : 8;
        for (int i = 0; i < 128 / w; i++) begin
            longint xa, xb, ma, mb, emax, fm;
            bit na, nb;
            xa = longint'((a >> (i*w)) & ((128'd1 << w) - 1));
            xb = longint'((b >> (i*w)) & ((128'd1 << w) - 1));
            ma = xa & ((64'd1 << (w-1)) - 1);
            mb = xb & ((64'd1 << (w-1)) - 1);
            emax = (64'd1 << ew) - 1;
            fm = (64'd1 << (w-1-ew)) - 1;
            na = ((ma >> (w-1-ew)) == emax) && ((ma & fm) != 0);
            nb = ((mb >> (w-1-ew)) == emax) && ((mb & fm) != 0);
            if (!na && !nb && ma <= mb)
                for (int k = 0; k < w; k++) r[i*w + k] = 1'b1;
        end
        if (!wide) r[127:64] = '0;
        return r;
    endfunction

    // Present one request, sample its result one clock later.
    task automatic run_op(input string req, input bit half, input bit wide,
                          input logic [127:0] a, input logic [127:0] b);
        logic [127:0] e;
        e = ref_mask(half, wide, a, b);
        @(negedge clk);
        in_valid = 1; in_insn = mk(half, wide, 5'd4, 5'd6, 5'd8);
        in_opa = a; in_opb = b;
        @(negedge clk);
        in_valid = 0;
        chk(out_valid == 1'b1, req, 128'(out_valid), 128'd1);
        chk(out_mask == e, req, out_mask, e);
    endtask

    task automatic t_reset();
        chk(out_valid == 0 && out_undef == 0, "R9 reset state",
            {126'd0, out_valid, out_undef}, 128'd0);
    endtask

    task automatic t_single();
        logic [127:0] a, b;
        a = {32'h40A0_0000, 32'h4040_0000, 32'hC000_0000, 32'h3F80_0000};
        b = {32'h4080_0000, 32'hC040_0000, 32'h3F80_0000, 32'h4000_0000};
        run_op("R1 single lanes", 0, 1, a, b);
        chk(out_mask == {32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF}, "R1 literal mask",
            out_mask, {32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF});
    endtask

    task automatic t_half();
        logic [127:0] a, b;
        a = {16'h3C00, 16'h4000, 16'hBC00, 16'h7C00, 16'h0001, 16'h8000, 16'h4400, 16'h3800};
        b = {16'h4000, 16'h3C00, 16'h3C00, 16'h7BFF, 16'h0002, 16'h0000, 16'hC400, 16'hB400};
        run_op("R2 half lanes", 1, 1, a, b);
        a = {8{16'h3C00}};
        b = {4{32'h3C00_3C00}};
        run_op("R2 half all equal", 1, 1, a, b);
    endtask

    task automatic t_len();
        logic [127:0] a, b;
        a = {32'h3F80_0000, 32'h3F80_0000, 32'h4000_0000, 32'h3F80_0000};
        b = {32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 32'h4000_0000};
        run_op("R3 64-bit single", 0, 0, a, b);
        chk(out_mask[127:64] == '0, "R3 upper zero", out_mask, 128'h0);
        run_op("R3 64-bit half", 1, 0, {8{16'h0000}}, {8{16'h3C00}});
    endtask

    task automatic t_sign();
        logic [127:0] a, b;
        a = {32'h8000_0000, 32'h7F80_0000, 32'h0000_0001, 32'hFF7F_FFFF};
        b = {32'h0000_0000, 32'h7F7F_FFFF, 32'h8000_0002, 32'h7F80_0000};
        run_op("R4 zeros inf subnormal", 0, 1, a, b);
        chk(out_mask[127:96] == '1, "R4 +0 vs -0", out_mask, {32'hFFFF_FFFF, 96'h0});
    endtask

    task automatic t_nan();
        logic [127:0] a, b;
        a = {32'h7FC0_0000, 32'h3F80_0000, 32'hFF80_0001, 32'h7F80_0000};
        b = {32'h7FC0_0000, 32'h7F80_0001, 32'h7F80_0000, 32'h7F80_0000};
        run_op("R5 single NaN", 0, 1, a, b);
        a = {16'h7E00, 16'h3C00, 16'h0000, 16'h7C01, 16'h7C00, 16'hFE00, 16'h0000, 16'h3C00};
        b = {16'h7C00, 16'h7D00, 16'h7C01, 16'h3C00, 16'h7C00, 16'h0000, 16'h0000, 16'h3C00};
        run_op("R5 half NaN", 1, 1, a, b);
    endtask

    task automatic t_nomatch();
        int bits[6] = '{23, 24, 21, 8, 4, 25};
        foreach (bits[i]) begin
            @(negedge clk);
            in_valid = 1; in_insn = mk(0, 1, 5'd2, 5'd2, 5'd2) ^ (32'd1 << bits[i]);
            @(negedge clk);
            in_valid = 0;
            chk(out_valid == 0 && out_undef == 0, "R6 non-matching ignored",
                {126'd0, out_valid, out_undef}, 128'd0);
        end
    endtask

    task automatic t_odd();
        logic [4:0] d[3] = '{5'd3, 5'd2, 5'd2};
        logic [4:0] n[3] = '{5'd2, 5'd17, 5'd2};
        logic [4:0] m[3] = '{5'd2, 5'd2, 5'd9};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1; in_insn = mk(0, 1, d[i], n[i], m[i]);
            @(negedge clk);
            in_valid = 0;
            chk(out_undef == 1 && out_valid == 0, "R7 odd register wide",
                {126'd0, out_valid, out_undef}, 128'd1);
            @(negedge clk);
            chk(out_undef == 0, "R7 undef single pulse", 128'(out_undef), 128'd0);
        end
        @(negedge clk);
        in_valid = 1; in_insn = mk(1, 0, 5'd3, 5'd5, 5'd7);
        in_opa = '0; in_opb = '0;
        @(negedge clk);
        in_valid = 0;
        chk(out_valid == 1 && out_undef == 0 && out_rd == 5'd3, "R7 odd ok in 64-bit",
            {121'd0, out_rd, out_valid, out_undef}, {121'd0, 5'd3, 1'b1, 1'b0});
    endtask

    task automatic t_b2b();
        @(negedge clk);
        in_valid = 1; in_insn = mk(0, 1, 5'd18, 5'd0, 5'd2);
        in_opa = {4{32'h3F80_0000}}; in_opb = {4{32'h4000_0000}};
        @(negedge clk);
        chk(out_valid == 1 && out_rd == 5'd18 && out_mask == '1, "R8 first result",
            {out_mask[121:0], out_rd, out_valid}, {122'h3FF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 5'd18, 1'b1});
        in_insn = mk(0, 1, 5'd20, 5'd0, 5'd2);
        in_opa = {4{32'h4000_0000}}; in_opb = {4{32'h3F80_0000}};
        @(negedge clk);
        in_valid = 0;
        chk(out_valid == 1 && out_rd == 5'd20 && out_mask == '0, "R8 second result",
            {out_mask[121:0], out_rd, out_valid}, {122'd0, 5'd20, 1'b1});
        @(negedge clk);
        chk(out_valid == 0, "R8 valid drops", 128'(out_valid), 128'd0);
    endtask

    task automatic t_reset_drop();
        @(negedge clk);
        in_valid = 1; in_insn = mk(0, 1, 5'd2, 5'd2, 5'd2); rst = 1;
        @(negedge clk);
        in_valid = 0; rst = 0;
        chk(out_valid == 0 && out_undef == 0, "R9 reset drops request",
            {126'd0, out_valid, out_undef}, 128'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        t_reset();
        t_single();
        t_half();
        t_len();
        t_sign();
        t_nan();
        t_nomatch();
        t_odd();
        t_b2b();
        t_reset_drop();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule